// File: doc/BRIEF.md
# Rotating Operand Delivery Buffer

This block sits between one register quadrant's common data bus and a pair of function units, for the three-operand multiply-add case. Operands come in on three entry lanes. They may arrive all in one cycle, or one at a time on a single lane. Each operand carries the index of the operand slot it belongs in. The buffer keeps the operands in a ring of three slots and steps each misplaced operand forward until it reaches its slot. An operand that is already in its slot stays put. Once every slot holds its own operand, the block tells the function unit that the operand set is complete. When the function unit takes the set, the ring empties.

The result side uses the same ring mechanism. A result enters at slot 0 with a destination index. It is stepped round to the outgoing slot of that index, and it is presented there until the consumer of that slot acknowledges it. Rotating a small ring takes the place of a full crossbar between bus lanes and operand ports. Because of this, serial and parallel arrival need no separate paths: serial arrival only costs extra cycles.

Top module: `rot_operand_buffer`

## Requirements
- R1: After reset, opsComplete is low, every inReady bit and resReady are high, and outValid is all zero.
- R2: Entry lane k writes slot k. An operand whose target equals k is in place on arrival. inReady[k] is low while slot k holds an operand, and also in any cycle in which an operand is moving into slot k. Operand slot i appears on opData bits [i*DATA_W +: DATA_W] and target field i on inTarget bits [i*2 +: 2].
- R3: Each cycle, every misplaced entry hops to the next slot ahead (index plus one, wrapping) that does not hold an in-place entry. It hops only if that slot is empty, or if its occupant hops in the same cycle. In-place entries never move.
- R4: opsComplete goes high in the cycle after all three slots hold in-place operands. Three aligned parallel operands give opsComplete after the second edge. A ring shifted by one gives it after the third edge, a ring shifted by two after the fourth, and a swap around an in-place slot after the third.
- R5: opsComplete stays high until fuAccept is sampled high with it. That edge empties all slots, and opsComplete is then low with all inReady bits high.
- R6: fuAccept sampled while opsComplete is low has no effect.
- R7: In serial delivery on lane 0, with targets 2, 1 and 0 each presented as soon as inReady[0] allows, the first operand is taken on edge 1, inReady[0] is high again after edges 2 and 4, and opsComplete is first high after edge 6.
- R8: A result accepted with destination d enters slot 0 and moves under R3. outValid[d] rises once it sits in slot d, with its data on outData bits [d*DATA_W +: DATA_W]. Destination 0 shows after edge 1 and destination 2 after edge 3.
- R9: outAck[d] sampled with outValid[d] high empties slot d on that edge. outAck on a slot without an in-place result has no effect.
- R10: resReady is low while slot 0 of the result ring is occupied, or while a result is moving into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 3 | Operand present on each entry lane |
| inReady | output | 3 | Entry lane may load this cycle |
| inData | input | 3*DATA_W | Operand value per lane |
| inTarget | input | 6 | Target operand slot per lane, 2 bits each |
| opsComplete | output | 1 | All three operands are in their slots |
| opData | output | 3*DATA_W | Operand values by slot |
| fuAccept | input | 1 | Function unit takes the complete operand set |
| resValid | input | 1 | Result offered |
| resReady | output | 1 | Result entry slot can load |
| resData | input | DATA_W | Result value |
| resDest | input | 2 | Destination outgoing slot |
| outValid | output | 3 | Result present in its destination slot |
| outData | output | 3*DATA_W | Result values by slot |
| outAck | input | 3 | Consumer of each outgoing slot takes the result |

## Verification
Every slot is a single register, so each hop, each load and each acknowledgement shows at the ports right after the edge that performs it. opsComplete adds one more register, so it lags in-place completion by one edge. The expected edge numbers in R4, R7 and R8 are counted from the edge that loads the first entry. Inputs are driven on the falling edge and outputs are sampled on the falling edge after the counted rising edge. Each check is also made one edge before the expected rise, to confirm the output is not yet high.

// File: rtl/rot_buf_pkg.sv
package rot_buf_pkg;
  localparam int RING_SLOTS = 3;
  localparam int SLOT_IDX_W = $clog2(RING_SLOTS);

  typedef logic [SLOT_IDX_W-1:0] slotIdx_t;

  // strobes from ring control to ring storage
  typedef struct packed {
    logic [RING_SLOTS-1:0] load;
    logic [RING_SLOTS-1:0] moveIn;
    logic [RING_SLOTS-1:0] moveOut;
    logic [RING_SLOTS-1:0] clear;
    slotIdx_t [RING_SLOTS-1:0] srcSel;
  } ringStrobe_t;
endpackage

// File: rtl/rot_ring_ctrl.sv
module rot_ring_ctrl
  import rot_buf_pkg::*;
#(
  parameter int IN_LANES = RING_SLOTS
) (
  input  logic [RING_SLOTS-1:0]     slotValid,
  input  slotIdx_t [RING_SLOTS-1:0] slotTgt,
  input  logic [IN_LANES-1:0]       laneValid,
  input  logic [RING_SLOTS-1:0]     clrReq,
  output logic [IN_LANES-1:0]       laneReady,
  output logic [RING_SLOTS-1:0]     slotPlaced,
  output ringStrobe_t               strobe
);
  logic [RING_SLOTS-1:0] misplaced;
  logic [RING_SLOTS-1:0] moveVec;
  slotIdx_t [RING_SLOTS-1:0] destIdx;

  always_comb begin
    for (int i = 0; i < RING_SLOTS; i++) begin
      slotPlaced[i] = slotValid[i] && (slotTgt[i] == slotIdx_t'(i));
      misplaced[i]  = slotValid[i] && (slotTgt[i] != slotIdx_t'(i));
    end
  end

  // hop target: next slot ahead not holding an in-place entry;
  // hop allowed when the walk over such slots meets an empty one
  // or wraps round through misplaced entries only
  always_comb begin
    int  j;
    logic found;
    logic walkDone;
    logic pathOk;
    for (int i = 0; i < RING_SLOTS; i++) begin
      destIdx[i] = slotIdx_t'(i);
      found    = 1'b0;
      walkDone = 1'b0;
      pathOk   = 1'b0;
      for (int s = 1; s < RING_SLOTS; s++) begin
        j = (i + s) % RING_SLOTS;
        if (!slotPlaced[j] && !found) begin
          destIdx[i] = slotIdx_t'(j);
          found = 1'b1;
        end
        if (!slotPlaced[j] && !walkDone && !slotValid[j]) begin
          pathOk   = 1'b1;
          walkDone = 1'b1;
        end
      end
      if (!walkDone) pathOk = 1'b1;
      moveVec[i] = misplaced[i] && found && pathOk;
    end
  end

  always_comb begin
    strobe = '0;
    for (int i = 0; i < RING_SLOTS; i++) begin
      if (moveVec[i]) begin
        strobe.moveOut[i]          = 1'b1;
        strobe.moveIn[destIdx[i]]  = 1'b1;
        strobe.srcSel[destIdx[i]]  = slotIdx_t'(i);
      end
      strobe.clear[i] = clrReq[i] && slotPlaced[i];
    end
    for (int k = 0; k < IN_LANES; k++) begin
      laneReady[k]   = !slotValid[k] && !strobe.moveIn[k];
      strobe.load[k] = laneValid[k] && laneReady[k];
    end
  end
endmodule

// File: rtl/rot_ring_data.sv
module rot_ring_data
  import rot_buf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IN_LANES = RING_SLOTS
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  ringStrobe_t                           strobe,
  input  logic [IN_LANES-1:0][DATA_W-1:0]       laneData,
  input  slotIdx_t [IN_LANES-1:0]               laneTgt,
  output logic [RING_SLOTS-1:0]                 slotValid,
  output slotIdx_t [RING_SLOTS-1:0]             slotTgt,
  output logic [RING_SLOTS-1:0][DATA_W-1:0]     slotData
);
  for (genvar g = 0; g < RING_SLOTS; g++) begin : g_slot
    logic              loadEn;
    logic [DATA_W-1:0] loadData;
    slotIdx_t          loadTgt;
    logic              validQ;
    slotIdx_t          tgtQ;
    logic [DATA_W-1:0] dataQ;

    if (g < IN_LANES) begin : g_lane
      assign loadEn   = strobe.load[g];
      assign loadData = laneData[g];
      assign loadTgt  = laneTgt[g];
    end else begin : g_noLane
      assign loadEn   = 1'b0;
      assign loadData = '0;
      assign loadTgt  = '0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ <= 1'b0;
        tgtQ   <= '0;
        dataQ  <= '0;
      end else if (loadEn) begin
        validQ <= 1'b1;
        tgtQ   <= loadTgt;
        dataQ  <= loadData;
      end else if (strobe.moveIn[g]) begin
        validQ <= 1'b1;
        tgtQ   <= slotTgt[strobe.srcSel[g]];
        dataQ  <= slotData[strobe.srcSel[g]];
      end else if (strobe.moveOut[g] || strobe.clear[g]) begin
        validQ <= 1'b0;
      end
    end

    assign slotValid[g] = validQ;
    assign slotTgt[g]   = tgtQ;
    assign slotData[g]  = dataQ;
  end
endmodule

// File: rtl/rot_operand_buffer.sv
module rot_operand_buffer
  import rot_buf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [RING_SLOTS-1:0]              inValid,
  output logic [RING_SLOTS-1:0]              inReady,
  input  logic [RING_SLOTS*DATA_W-1:0]       inData,
  input  logic [RING_SLOTS*SLOT_IDX_W-1:0]   inTarget,
  output logic                               opsComplete,
  output logic [RING_SLOTS*DATA_W-1:0]       opData,
  input  logic                               fuAccept,
  input  logic                               resValid,
  output logic                               resReady,
  input  logic [DATA_W-1:0]                  resData,
  input  logic [SLOT_IDX_W-1:0]              resDest,
  output logic [RING_SLOTS-1:0]              outValid,
  output logic [RING_SLOTS*DATA_W-1:0]       outData,
  input  logic [RING_SLOTS-1:0]              outAck
);
  // operand ring
  ringStrobe_t                       opStrobe;
  logic [RING_SLOTS-1:0]             opValid;
  slotIdx_t [RING_SLOTS-1:0]         opTgt;
  logic [RING_SLOTS-1:0][DATA_W-1:0] opSlotData;
  logic [RING_SLOTS-1:0]             opPlaced;
  logic [RING_SLOTS-1:0][DATA_W-1:0] opLaneData;
  slotIdx_t [RING_SLOTS-1:0]         opLaneTgt;
  logic                              opsCompleteQ;
  logic                              acceptFire;

  assign opLaneData = inData;
  assign opLaneTgt  = inTarget;
  assign acceptFire = opsCompleteQ && fuAccept;

  rot_ring_ctrl #(.IN_LANES(RING_SLOTS)) u_opCtrl (
    .slotValid (opValid),
    .slotTgt   (opTgt),
    .laneValid (inValid),
    .clrReq    ({RING_SLOTS{acceptFire}}),
    .laneReady (inReady),
    .slotPlaced(opPlaced),
    .strobe    (opStrobe)
  );

  rot_ring_data #(.DATA_W(DATA_W), .IN_LANES(RING_SLOTS)) u_opData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (opStrobe),
    .laneData (opLaneData),
    .laneTgt  (opLaneTgt),
    .slotValid(opValid),
    .slotTgt  (opTgt),
    .slotData (opSlotData)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) opsCompleteQ <= 1'b0;
    else       opsCompleteQ <= (&opPlaced) && !acceptFire;
  end

  assign opsComplete = opsCompleteQ;
  assign opData      = opSlotData;

  // result ring: one entry lane at slot 0
  ringStrobe_t                       resStrobe;
  logic [RING_SLOTS-1:0]             resSlotValid;
  slotIdx_t [RING_SLOTS-1:0]         resSlotTgt;
  logic [RING_SLOTS-1:0][DATA_W-1:0] resSlotData;
  logic [0:0][DATA_W-1:0]            resLaneData;
  slotIdx_t [0:0]                    resLaneTgt;
  logic [0:0]                        resLaneReady;

  assign resLaneData[0] = resData;
  assign resLaneTgt[0]  = resDest;
  assign resReady       = resLaneReady[0];

  rot_ring_ctrl #(.IN_LANES(1)) u_resCtrl (
    .slotValid (resSlotValid),
    .slotTgt   (resSlotTgt),
    .laneValid (resValid),
    .clrReq    (outAck),
    .laneReady (resLaneReady),
    .slotPlaced(outValid),
    .strobe    (resStrobe)
  );

  rot_ring_data #(.DATA_W(DATA_W), .IN_LANES(1)) u_resData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (resStrobe),
    .laneData (resLaneData),
    .laneTgt  (resLaneTgt),
    .slotValid(resSlotValid),
    .slotTgt  (resSlotTgt),
    .slotData (resSlotData)
  );

  assign outData = resSlotData;
endmodule

// File: rtl/rot_operand_buffer_chk.sv
module rot_operand_buffer_chk
  import rot_buf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [RING_SLOTS-1:0]        inReady,
  input logic                         opsComplete,
  input logic                         fuAccept,
  input logic                         resReady,
  input logic [RING_SLOTS-1:0]        outValid,
  input logic [RING_SLOTS*DATA_W-1:0] outData,
  input logic [RING_SLOTS-1:0]        outAck
);
  // R2: a full operand set leaves no lane able to load
  p_full_blocks_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    opsComplete |-> (inReady == '0));

  // R5: complete is held until taken
  p_complete_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opsComplete && !fuAccept) |=> opsComplete);

  // R5: taking the set empties the ring
  p_accept_empties_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opsComplete && fuAccept) |=> (!opsComplete && (inReady == '1)));

  // R10: result at slot 0 blocks new result entry
  p_slot0_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    outValid[0] |-> !resReady);

  for (genvar g = 0; g < RING_SLOTS; g++) begin : g_chk
    // R3: an in-place result neither moves nor changes until acknowledged
    p_result_held_r3: assert property (@(posedge clk) disable iff (!rstN)
      (outValid[g] && !outAck[g]) |=>
        (outValid[g] && $stable(outData[g*DATA_W +: DATA_W])));

    // R9: acknowledge empties the slot
    p_ack_empties_r9: assert property (@(posedge clk) disable iff (!rstN)
      (outValid[g] && outAck[g]) |=> !outValid[g]);
  end
endmodule

bind rot_operand_buffer rot_operand_buffer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inReady    (inReady),
  .opsComplete(opsComplete),
  .fuAccept   (fuAccept),
  .resReady   (resReady),
  .outValid   (outValid),
  .outData    (outData),
  .outAck     (outAck)
);

// File: tb/tb_rot_operand_buffer.sv
`timescale 1ns/1ps
module tb_rot_operand_buffer;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    inValid = '0;
  logic [2:0]    inReady;
  logic [3*W-1:0] inData = '0;
  logic [5:0]    inTarget = '0;
  logic          opsComplete;
  logic [3*W-1:0] opData;
  logic          fuAccept = 1'b0;
  logic          resValid = 1'b0;
  logic          resReady;
  logic [W-1:0]  resData = '0;
  logic [1:0]    resDest = '0;
  logic [2:0]    outValid;
  logic [3*W-1:0] outData;
  logic [2:0]    outAck = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rot_operand_buffer #(.DATA_W(W)) dut (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady), .inData(inData), .inTarget(inTarget),
    .opsComplete(opsComplete), .opData(opData), .fuAccept(fuAccept),
    .resValid(resValid), .resReady(resReady), .resData(resData), .resDest(resDest),
    .outValid(outValid), .outData(outData), .outAck(outAck)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic test_reset();
    chk("R1 opsComplete", opsComplete, 0);
    chk("R1 inReady", inReady, 3'b111);
    chk("R1 resReady", resReady, 1);
    chk("R1 outValid", outValid, 3'b000);
  endtask

  // all three lanes in one cycle; lane k has target tk
  task automatic test_parallel(input int t0, input int t1, input int t2,
                               input int riseEdge, input bit earlyAccept, input string tag);
    logic [2:0][W-1:0] d;
    logic [2:0][W-1:0] expOps;
    for (int k = 0; k < 3; k++) d[k] = 32'hC0DE_0000 + (riseEdge << 8) + k;
    expOps[t0] = d[0];
    expOps[t1] = d[1];
    expOps[t2] = d[2];
    inValid  = 3'b111;
    inData   = d;
    inTarget = {2'(t2), 2'(t1), 2'(t0)};
    step();
    inValid = '0;
    chk({"R2 lanes blocked after load ", tag}, inReady, 3'b000);
    for (int e = 1; e <= riseEdge; e++) begin
      if (e == riseEdge - 1) chk({"R4 not yet complete ", tag}, opsComplete, 0);
      if (e == riseEdge) begin
        chk({"R4 complete on time ", tag}, opsComplete, 1);
        chk({"R3 operands in slots ", tag}, opData, expOps);
      end
      fuAccept = earlyAccept && (e == 1);
      if (e < riseEdge) step();
    end
    fuAccept = 1'b0;
    if (earlyAccept) chk({"R6 early accept ignored ", tag}, opData, expOps);
    step();
    chk({"R5 held without accept ", tag}, opsComplete, 1);
    fuAccept = 1'b1;
    step();
    fuAccept = 1'b0;
    chk({"R5 accept clears ", tag}, opsComplete, 0);
    chk({"R5 ring empty ", tag}, inReady, 3'b111);
  endtask

  task automatic test_serial();
    logic [W-1:0] a = 32'hAAAA_0002;
    logic [W-1:0] b = 32'hBBBB_0001;
    logic [W-1:0] c = 32'hCCCC_0000;
    inValid = 3'b001; inData = {64'h0, a}; inTarget = 6'd2;
    step(); // edge 1
    inValid = '0;
    chk("R2 entry and hop target blocked", inReady, 3'b100);
    step(); // edge 2
    chk("R7 lane0 free after edge 2", inReady[0], 1);
    inValid = 3'b001; inData = {64'h0, b}; inTarget = 6'd1;
    step(); // edge 3
    inValid = '0;
    chk("R3 hop in progress blocks lanes", inReady, 3'b000);
    step(); // edge 4
    chk("R7 lane0 free after edge 4", inReady[0], 1);
    inValid = 3'b001; inData = {64'h0, c}; inTarget = 6'd0;
    step(); // edge 5
    inValid = '0;
    chk("R7 not complete after edge 5", opsComplete, 0);
    step(); // edge 6
    chk("R7 complete after edge 6", opsComplete, 1);
    chk("R7 serial operands placed", opData, {a, b, c});
    fuAccept = 1'b1;
    step();
    fuAccept = 1'b0;
    chk("R5 serial accept clears", opsComplete, 0);
  endtask

  task automatic test_result_dest0();
    resValid = 1'b1; resData = 32'hD000_0000; resDest = 2'd0;
    step();
    resValid = 1'b0;
    chk("R8 dest0 shows after edge 1", outValid, 3'b001);
    chk("R8 dest0 data", outData[W-1:0], 32'hD000_0000);
    chk("R10 slot0 busy", resReady, 0);
    step();
    chk("R3 in-place result held", outValid, 3'b001);
    outAck = 3'b001;
    step();
    outAck = '0;
    chk("R9 ack clears", outValid, 3'b000);
    chk("R10 free after ack", resReady, 1);
  endtask

  task automatic test_result_dest2();
    resValid = 1'b1; resData = 32'hE000_0002; resDest = 2'd2;
    step(); // edge 1
    resValid = 1'b0;
    chk("R8 dest2 not at edge 1", outValid, 3'b000);
    chk("R10 slot0 occupied", resReady, 0);
    step(); // edge 2
    chk("R8 dest2 not at edge 2", outValid, 3'b000);
    chk("R10 slot0 vacated", resReady, 1);
    step(); // edge 3
    chk("R8 dest2 shows after edge 3", outValid, 3'b100);
    chk("R8 dest2 data", outData[3*W-1:2*W], 32'hE000_0002);
    outAck = 3'b001;
    step();
    outAck = '0;
    chk("R9 ack on empty slot ignored", outValid, 3'b100);
    outAck = 3'b100;
    step();
    outAck = '0;
    chk("R9 ack clears dest2", outValid, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_parallel(0, 1, 2, 2, 1'b0, "aligned");
    test_parallel(1, 2, 0, 3, 1'b0, "shift1");
    test_parallel(2, 0, 1, 4, 1'b1, "shift2");
    test_parallel(0, 2, 1, 3, 1'b0, "swap");
    test_serial();
    test_result_dest0();
    test_result_dest2();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule